// File: doc/BRIEF.md
# Switch Input and Segment Display Port Pair

This block places two byte-wide ports in the I/O space of a processor bus. The first is a read-only port. On a decoded I/O read it gates the state of eight switches onto the read data bus. At all other times the read bus carries zeros and the valid flag is low. The second is a write-only register that captures the bus write data on a decoded I/O write and holds it as the pattern for a seven-segment display.

The strobes are the memory-versus-I/O select (low for an I/O cycle) and the active-low read and write strobes. Each strobe lasts a single cycle. A parameter chooses between two address decoders. One compares the whole 16-bit port address. The other compares only the low four address bits, so every address that ends in the same nibble reaches the same port.

A helper output gives the segment pattern for the number of the lowest closed switch. Software can read the switches and copy this pattern to the display register as a self-test.

Top module: `swdisp_port`

## Requirements
- R1: When `mio_n` is low, `rd_n` is low and the address selects the input port (default 16'h0740), `rd_valid` is 1 in the same cycle. `rd_data` bit i equals `sw_in` bit i, where bit i is switch i+1 and a closed switch reads 1.
- R2: In every other cycle `rd_valid` is 0 and `rd_data` is all zeros. This covers a memory cycle (`mio_n` high), `rd_n` high and an address that does not match.
- R3: When `mio_n` is low, `wr_n` is low and the address selects the output port (default 16'h0741), `seg` shows that cycle's `wr_data` after the next rising clock edge.
- R4: A write strobe in a memory cycle, or to an address that does not select the output port, leaves `seg` unchanged. Without a write, `seg` keeps its last value.
- R5: Asserting `rst_n` low clears `seg` to all zeros, which is a blank display.
- R6: With full decoding (`FULL_DECODE`=1), an address that differs from a port address in any bit from 15 down to 4 selects neither port.
- R7: With nibble decoding (`FULL_DECODE`=0), only address bits 3..0 are compared. Any address ending in 4'h0 selects the input port, and any address ending in 4'h1 selects the output port.
- R8: `hint_seg` is active high with bit order g,f,e,d,c,b,a from bit 6 down to bit 0. It shows the digit of the lowest-numbered closed switch, with 1..8 encoded as 06,5B,4F,66,6D,7D,07,7F hex. It is 00 when no switch is closed.
- R9: `seg` bits 6..0 drive segments g..a, and bit 7 drives the decimal point. All are active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Port address |
| mio_n | input | 1 | Low marks an I/O cycle, high a memory cycle |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wr_data | input | 8 | Bus write data |
| sw_in | input | 8 | Switch states, 1 = closed |
| rd_data | output | 8 | Gated read data, zero when not selected |
| rd_valid | output | 1 | High while the input port drives read data |
| seg | output | 8 | Display register: decimal point, g..a |
| hint_seg | output | 7 | Pattern for the lowest closed switch |

## Verification
Two instances run side by side on the same stimulus, one with full decoding and one with nibble decoding. The addresses are drawn from four groups: the exact port addresses, nibble aliases, addresses one upper bit away from a port, and fully random values. The first three groups are what separate the two decoders. The memory-versus-I/O select and both strobes are randomized on their own, so a write in a memory cycle or to an unmatched address shows up as a held display. The switch patterns include all-open, single closed switches and random sets with several closed. These tell apart a blank hint, each digit, and the lowest-wins rule.

// File: rtl/swdisp_pkg.sv
package swdisp_pkg;
   localparam int SEG_N = 7;
   typedef logic [SEG_N-1:0] seg_t;
   localparam seg_t SEG_BLANK = 7'h00;
endpackage

// File: rtl/swdisp_decode.sv
module swdisp_decode #(
   parameter int          ADDR_W      = 16,
   parameter logic [15:0] IN_PORT     = 16'h0740,
   parameter logic [15:0] OUT_PORT    = 16'h0741,
   parameter bit          FULL_DECODE = 1'b1
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              mio_n,
   input  logic              rd_n,
   input  logic              wr_n,
   output logic              rd_sel,
   output logic              wr_sel
);
   localparam int NIB_W = 4;

   logic hit_in, hit_out;
   logic io_cyc;

   generate
      if (FULL_DECODE) begin : g_full
         assign hit_in  = (io_addr == IN_PORT[ADDR_W-1:0]);
         assign hit_out = (io_addr == OUT_PORT[ADDR_W-1:0]);
      end else begin : g_nibble
         assign hit_in  = (io_addr[NIB_W-1:0] == IN_PORT[NIB_W-1:0]);
         assign hit_out = (io_addr[NIB_W-1:0] == OUT_PORT[NIB_W-1:0]);
      end
   endgenerate

   assign io_cyc = ~mio_n;
   assign rd_sel = io_cyc & ~rd_n & hit_in;
   assign wr_sel = io_cyc & ~wr_n & hit_out;
endmodule

// File: rtl/swdisp_latch.sv
module swdisp_latch #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dout <= '0;
      else if (load) dout <= din;
   end
endmodule

// File: rtl/swdisp_glyph.sv
module swdisp_glyph
   import swdisp_pkg::*;
#(
   parameter int SW_N = 8
) (
   input  logic [SW_N-1:0] sw,
   output seg_t            glyph
);
   localparam int IDX_W = $clog2(SW_N + 1);

   logic [IDX_W-1:0] num;

   always_comb begin
      num = '0;
      for (int i = SW_N - 1; i >= 0; i--) begin
         if (sw[i]) num = IDX_W'(i + 1);
      end
   end

   always_comb begin
      unique case (int'(num))
         1:       glyph = 7'h06;
         2:       glyph = 7'h5B;
         3:       glyph = 7'h4F;
         4:       glyph = 7'h66;
         5:       glyph = 7'h6D;
         6:       glyph = 7'h7D;
         7:       glyph = 7'h07;
         8:       glyph = 7'h7F;
         9:       glyph = 7'h6F;
         default: glyph = SEG_BLANK;
      endcase
   end
endmodule

// File: rtl/swdisp_port.sv
module swdisp_port
   import swdisp_pkg::*;
#(
   parameter int          DATA_W      = 8,
   parameter int          ADDR_W      = 16,
   parameter logic [15:0] IN_PORT     = 16'h0740,
   parameter logic [15:0] OUT_PORT    = 16'h0741,
   parameter bit          FULL_DECODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              mio_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] sw_in,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [DATA_W-1:0] seg,
   output seg_t              hint_seg
);
   generate
      if (DATA_W < SEG_N || DATA_W > 9) begin : g_bad_width
         $error("swdisp_port: DATA_W must lie in 7..9");
      end
      if (ADDR_W > 16 || ADDR_W < 4) begin : g_bad_addr
         $error("swdisp_port: ADDR_W must lie in 4..16");
      end
      if (FULL_DECODE && IN_PORT == OUT_PORT) begin : g_same_full
         $error("swdisp_port: port addresses collide");
      end
      if (!FULL_DECODE && IN_PORT[3:0] == OUT_PORT[3:0]) begin : g_same_nib
         $error("swdisp_port: port nibbles collide");
      end
   endgenerate

   logic rd_sel, wr_sel;

   swdisp_decode #(
      .ADDR_W(ADDR_W), .IN_PORT(IN_PORT), .OUT_PORT(OUT_PORT),
      .FULL_DECODE(FULL_DECODE)
   ) u_dec (
      .io_addr(io_addr), .mio_n(mio_n), .rd_n(rd_n), .wr_n(wr_n),
      .rd_sel(rd_sel), .wr_sel(wr_sel)
   );

   assign rd_data  = rd_sel ? sw_in : '0;
   assign rd_valid = rd_sel;

   swdisp_latch #(.DATA_W(DATA_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .load(wr_sel), .din(wr_data), .dout(seg)
   );

   swdisp_glyph #(.SW_N(DATA_W)) u_glyph (
      .sw(sw_in), .glyph(hint_seg)
   );
endmodule

// File: rtl/swdisp_port_chk.sv
module swdisp_port_chk #(
   parameter int          DATA_W      = 8,
   parameter int          ADDR_W      = 16,
   parameter logic [15:0] IN_PORT     = 16'h0740,
   parameter logic [15:0] OUT_PORT    = 16'h0741,
   parameter bit          FULL_DECODE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              mio_n,
   input logic              rd_n,
   input logic              wr_n,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] sw_in,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_valid,
   input logic [DATA_W-1:0] seg,
   input logic [6:0]        hint_seg
);
   logic out_hit;
   assign out_hit = FULL_DECODE ? (io_addr == OUT_PORT[ADDR_W-1:0])
                                : (io_addr[3:0] == OUT_PORT[3:0]);

   // R2: the read bus is quiet whenever the port is not driving it
   a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> rd_data == '0);

   // R1: a valid read needs an I/O cycle with the read strobe low, and returns the switches
   a_r1_valid_needs_io_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (!mio_n && !rd_n && rd_data == sw_in));

   // R3: a decoded write shows on the display one edge later
   a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!mio_n && !wr_n && out_hit) |=> seg == $past(wr_data));

   // R4: without an I/O write strobe the display holds
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mio_n && !wr_n) |=> $stable(seg));

   // R8: no closed switch gives a blank hint
   a_r8_blank_hint: assert property (@(posedge clk) disable iff (!rst_n)
      sw_in == '0 |-> hint_seg == 7'h00);
endmodule

bind swdisp_port swdisp_port_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IN_PORT(IN_PORT),
   .OUT_PORT(OUT_PORT), .FULL_DECODE(FULL_DECODE)
) u_chk (.*);

// File: tb/swdisp_port_tb.sv
module swdisp_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = 16'h0;
   logic        mio_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [7:0]  wr_data = 8'h0, sw_in = 8'h0;
   logic [7:0]  rd_data_f, rd_data_n, seg_f, seg_n;
   logic        rd_valid_f, rd_valid_n;
   logic [6:0]  hint_f, hint_n;

   int n_vec = 0, n_bad = 0;
   logic [7:0] exp_seg_f = 8'h0, exp_seg_n = 8'h0;

   always #2.5 clk = ~clk;

   swdisp_port #(.FULL_DECODE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .mio_n(mio_n), .rd_n(rd_n),
      .wr_n(wr_n), .wr_data(wr_data), .sw_in(sw_in), .rd_data(rd_data_f),
      .rd_valid(rd_valid_f), .seg(seg_f), .hint_seg(hint_f));

   swdisp_port #(.FULL_DECODE(1'b0)) u_dut_nib (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .mio_n(mio_n), .rd_n(rd_n),
      .wr_n(wr_n), .wr_data(wr_data), .sw_in(sw_in), .rd_data(rd_data_n),
      .rd_valid(rd_valid_n), .seg(seg_n), .hint_seg(hint_n));

   function automatic bit hit(input logic [15:0] a, input logic [15:0] port, input bit full);
      return full ? (a == port) : (a[3:0] == port[3:0]);
   endfunction

   function automatic logic [6:0] digit(input int d);
      case (d)
         1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F; 4: return 7'h66;
         5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07; 8: return 7'h7F;
         default: return 7'h00;
      endcase
   endfunction

   function automatic logic [6:0] exp_hint(input logic [7:0] s);
      for (int i = 0; i < 8; i++) if (s[i]) return digit(i + 1);
      return 7'h00;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] a, input logic m, input logic r,
                        input logic w, input logic [7:0] d, input logic [7:0] s);
      bit rf, rn, wf, wn;
      @(negedge clk);
      io_addr = a; mio_n = m; rd_n = r; wr_n = w; wr_data = d; sw_in = s;
      #1;
      rf = !m && !r && hit(a, 16'h0740, 1'b1);
      rn = !m && !r && hit(a, 16'h0740, 1'b0);
      wf = !m && !w && hit(a, 16'h0741, 1'b1);
      wn = !m && !w && hit(a, 16'h0741, 1'b0);
      // R1 R2 R6: full decoder read path
      check(rf ? "R1 full read" : "R2/R6 full quiet", rd_data_f, rf ? s : 8'h00);
      check("R1/R2 full valid", {7'h0, rd_valid_f}, {7'h0, rf});
      // R7: nibble decoder read path
      check("R7 nibble read", rd_data_n, rn ? s : 8'h00);
      check("R7 nibble valid", {7'h0, rd_valid_n}, {7'h0, rn});
      // R8: hint pattern
      check("R8 hint", {1'b0, hint_f}, {1'b0, exp_hint(s)});
      @(posedge clk);
      if (wf) exp_seg_f = d;
      if (wn) exp_seg_n = d;
      #1;
      // R3 R4 R9: display register, full and nibble
      check(wf ? "R3 full write" : "R4/R6 full hold", seg_f, exp_seg_f);
      check(wn ? "R7 nibble write" : "R4 nibble hold", seg_n, exp_seg_n);
   endtask

   function automatic logic [15:0] pick_addr();
      int k = $urandom % 6;
      logic [15:0] r = 16'($urandom);
      case (k)
         0: return 16'h0740;
         1: return 16'h0741;
         2: return {r[15:4], 4'h0};
         3: return {r[15:4], 4'h1};
         4: return r;
         default: return 16'h0740 ^ (16'h1 << (4 + ($urandom % 12))) ^ {15'h0, r[0]};
      endcase
   endfunction

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            n_bad++; n_vec++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R5: reset state is blank
      check("R5 reset full", seg_f, 8'h00);
      check("R5 reset nibble", seg_n, 8'h00);
      rst_n = 1'b1;
      // directed corners
      apply(16'h0740, 1'b0, 1'b0, 1'b1, 8'h00, 8'hA5);  // R1 read
      apply(16'h0740, 1'b1, 1'b0, 1'b1, 8'h00, 8'hA5);  // R2 memory cycle
      apply(16'h0741, 1'b0, 1'b1, 1'b0, 8'h5B, 8'h00);  // R3 write, R8 blank
      apply(16'h0741, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h00);  // R4 memory write ignored
      apply(16'h8741, 1'b0, 1'b1, 1'b0, 8'hC3, 8'h01);  // R6 upper bit, R7 alias write
      apply(16'h1230, 1'b0, 1'b0, 1'b1, 8'h00, 8'h80);  // R7 alias read, R8 digit 8
      apply(16'h0741, 1'b0, 1'b1, 1'b0, 8'h86, 8'h06);  // R9 decimal point set
      for (int i = 0; i < 8; i++)
         apply(16'h0740, 1'b0, 1'b0, 1'b1, 8'h00, 8'h01 << i);  // R8 each digit
      apply(16'h0740, 1'b0, 1'b0, 1'b1, 8'h00, 8'hFF);  // R8 lowest wins
      for (int i = 0; i < 400; i++)
         apply(pick_addr(), ($urandom % 4) == 0, 1'($urandom), 1'($urandom),
               8'($urandom), 8'($urandom) & 8'($urandom));
      // R5: mid-run reset blanks the display
      @(negedge clk);
      rst_n = 1'b0; exp_seg_f = 8'h0; exp_seg_n = 8'h0;
      #1;
      check("R5 mid reset full", seg_f, 8'h00);
      check("R5 mid reset nibble", seg_n, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      apply(16'h0741, 1'b0, 1'b1, 1'b0, 8'h7F, 8'h00);  // R3 after reset
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule